// File: doc/BRIEF.md
# Domain-Aware Result Bypass Network

This block sits between the execution ports and the operand inputs of the consumers that are waiting for results. In each cycle every execution port may present one result, made of a destination tag, a data word and a domain code. The block registers these results into a short age pipeline. The first stage of that pipeline also drives the register-file write path.

Consumers send lookups. Each lookup carries a source tag and the consumer's own domain. The block searches the staged results and returns a hit flag and the forwarded data. A result is visible at once to consumers in the same domain. A consumer in another domain sees it only after a programmable number of extra cycles. Once a result leaves the last stage, lookups for it miss, and the consumer must read the register file.

Top module: `bypass_net`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no register-file write is driven and every lookup reports a miss with zero data.
- R2: A result presented on port p with its valid bit set in cycle n drives port p's register-file write enable, tag and data in cycle n+1. The write lasts exactly one cycle.
- R3: Domain codes are 0 integer, 1 floating point and 2 SIMD. A lookup whose domain equals the producer's domain hits in cycles n+1 through n+1+XDOM_DLY and returns the producer's data. No delay is added.
- R4: A lookup from a different domain misses in cycles n+1 through n+XDOM_DLY. It hits only in cycle n+1+XDOM_DLY (default XDOM_DLY = 1).
- R5: From cycle n+2+XDOM_DLY onward, the result is no longer visible to any lookup, which then misses.
- R6: When results of different ages match a lookup, the most recently presented one is returned.
- R7: When results of the same age from several ports match a lookup, the lowest-numbered port wins.
- R8: A lookup whose request bit is low reports a miss with zero data, whatever the staged contents.
- R9: A miss always returns zero data.
- R10: A port whose valid bit is low produces neither a register-file write nor a forwardable entry, whatever its tag, data and domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_vld_i | input | NUM_PORTS | Result valid, one bit per execution port |
| res_tag_i | input | NUM_PORTS x TAG_W | Destination tag per port |
| res_data_i | input | NUM_PORTS x DATA_W | Result data per port |
| res_dom_i | input | NUM_PORTS x 2 | Producer domain per port |
| lk_req_i | input | NUM_LOOKUPS | Lookup request per consumer |
| lk_tag_i | input | NUM_LOOKUPS x TAG_W | Source tag searched by each consumer |
| lk_dom_i | input | NUM_LOOKUPS x 2 | Consumer domain |
| lk_hit_o | output | NUM_LOOKUPS | Lookup found a visible result |
| lk_data_o | output | NUM_LOOKUPS x DATA_W | Forwarded data, zero on miss |
| rf_we_o | output | NUM_PORTS | Register-file write enable per port |
| rf_tag_o | output | NUM_PORTS x TAG_W | Register-file write tag per port |
| rf_data_o | output | NUM_PORTS x DATA_W | Register-file write data per port |

## Verification
Two things can meet on the same tag in one cycle. A fresh result is visible only to its own domain, while an aged result with the same tag has just become visible across domains. The bench provokes this with directed back-to-back writes to one tag from different domains. It also runs a long random phase that draws tags from a pool of eight, so collisions are frequent. In the collision case, a same-domain consumer must receive the young data and a cross-domain consumer must receive the old data. A queue model that ages each entry by one per clock judges every lookup and every register-file write in every cycle.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    DOM_INT  = 2'd0,
    DOM_FP   = 2'd1,
    DOM_SIMD = 2'd2,
    DOM_RSVD = 2'd3
  } dom_e;
  localparam int DOM_W = 2;
endpackage

// File: rtl/bypass_stage_pipe.sv
module bypass_stage_pipe
  import bypass_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int TAG_W     = 7,
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 2
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic [NUM_PORTS-1:0]                        in_vld_i,
  input  logic [NUM_PORTS-1:0][TAG_W-1:0]             in_tag_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]            in_data_i,
  input  logic [NUM_PORTS-1:0][DOM_W-1:0]             in_dom_i,
  output logic [DEPTH-1:0][NUM_PORTS-1:0]             st_vld_o,
  output logic [DEPTH-1:0][NUM_PORTS-1:0][TAG_W-1:0]  st_tag_o,
  output logic [DEPTH-1:0][NUM_PORTS-1:0][DATA_W-1:0] st_data_o,
  output logic [DEPTH-1:0][NUM_PORTS-1:0][DOM_W-1:0]  st_dom_o
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [NUM_PORTS-1:0]             nxt_vld;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  nxt_tag;
    logic [NUM_PORTS-1:0][DATA_W-1:0] nxt_data;
    logic [NUM_PORTS-1:0][DOM_W-1:0]  nxt_dom;

    if (s == 0) begin : g_head
      assign nxt_vld  = in_vld_i;
      assign nxt_tag  = in_tag_i;
      assign nxt_data = in_data_i;
      assign nxt_dom  = in_dom_i;
    end else begin : g_body
      assign nxt_vld  = st_vld_o[s-1];
      assign nxt_tag  = st_tag_o[s-1];
      assign nxt_data = st_data_o[s-1];
      assign nxt_dom  = st_dom_o[s-1];

      assert_age_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (st_vld_o[s] == $past(st_vld_o[s-1])));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_vld_o[s]  <= '0;
        st_tag_o[s]  <= '0;
        st_data_o[s] <= '0;
        st_dom_o[s]  <= '0;
      end else begin
        st_vld_o[s] <= nxt_vld;
        for (int p = 0; p < NUM_PORTS; p++) begin
          // hold payload of empty slots to save toggles
          if (nxt_vld[p]) begin
            st_tag_o[s][p]  <= nxt_tag[p];
            st_data_o[s][p] <= nxt_data[p];
            st_dom_o[s][p]  <= nxt_dom[p];
          end
        end
      end
    end
  end

endmodule

// File: rtl/bypass_lookup.sv
module bypass_lookup
  import bypass_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int TAG_W     = 7,
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 2,
  parameter int XDOM_DLY  = 1
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic [DEPTH-1:0][NUM_PORTS-1:0]             st_vld_i,
  input  logic [DEPTH-1:0][NUM_PORTS-1:0][TAG_W-1:0]  st_tag_i,
  input  logic [DEPTH-1:0][NUM_PORTS-1:0][DATA_W-1:0] st_data_i,
  input  logic [DEPTH-1:0][NUM_PORTS-1:0][DOM_W-1:0]  st_dom_i,
  input  logic                                        req_i,
  input  logic [TAG_W-1:0]                            tag_i,
  input  logic [DOM_W-1:0]                            dom_i,
  output logic                                        hit_o,
  output logic [DATA_W-1:0]                           data_o
);

  logic [DEPTH-1:0][NUM_PORTS-1:0] vis;
  int unsigned                     sel_stage;
  logic [DOM_W-1:0]                sel_dom;

  // per-entry visibility: tag match, and domain match unless aged past penalty
  for (genvar s = 0; s < DEPTH; s++) begin : g_vis_s
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_vis_p
      localparam bit AGED = (s >= XDOM_DLY);
      assign vis[s][p] = req_i && st_vld_i[s][p] && (st_tag_i[s][p] == tag_i) &&
                         (AGED || (st_dom_i[s][p] == dom_i));
    end
  end

  // youngest stage first, then lowest port
  always_comb begin
    hit_o     = 1'b0;
    data_o    = '0;
    sel_stage = 0;
    sel_dom   = '0;
    for (int s = 0; s < DEPTH; s++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (!hit_o && vis[s][p]) begin
          hit_o     = 1'b1;
          data_o    = st_data_i[s][p];
          sel_stage = s;
          sel_dom   = st_dom_i[s][p];
        end
      end
    end
  end

  assert_hit_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> req_i);

  assert_miss_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (data_o == '0));

  assert_xdom_aged_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (sel_dom != dom_i)) |-> (sel_stage >= XDOM_DLY));

endmodule

// File: rtl/bypass_net.sv
module bypass_net
  import bypass_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int NUM_LOOKUPS = 4,
  parameter int TAG_W       = 7,
  parameter int DATA_W      = 64,
  parameter int XDOM_DLY    = 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_PORTS-1:0]                 res_vld_i,
  input  logic [NUM_PORTS-1:0][TAG_W-1:0]      res_tag_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]     res_data_i,
  input  logic [NUM_PORTS-1:0][1:0]            res_dom_i,
  input  logic [NUM_LOOKUPS-1:0]               lk_req_i,
  input  logic [NUM_LOOKUPS-1:0][TAG_W-1:0]    lk_tag_i,
  input  logic [NUM_LOOKUPS-1:0][1:0]          lk_dom_i,
  output logic [NUM_LOOKUPS-1:0]               lk_hit_o,
  output logic [NUM_LOOKUPS-1:0][DATA_W-1:0]   lk_data_o,
  output logic [NUM_PORTS-1:0]                 rf_we_o,
  output logic [NUM_PORTS-1:0][TAG_W-1:0]      rf_tag_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]     rf_data_o
);

  localparam int DEPTH = XDOM_DLY + 1;

  logic [DEPTH-1:0][NUM_PORTS-1:0]             st_vld;
  logic [DEPTH-1:0][NUM_PORTS-1:0][TAG_W-1:0]  st_tag;
  logic [DEPTH-1:0][NUM_PORTS-1:0][DATA_W-1:0] st_data;
  logic [DEPTH-1:0][NUM_PORTS-1:0][DOM_W-1:0]  st_dom;

  bypass_stage_pipe #(
    .NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (res_vld_i),
    .in_tag_i  (res_tag_i),
    .in_data_i (res_data_i),
    .in_dom_i  (res_dom_i),
    .st_vld_o  (st_vld),
    .st_tag_o  (st_tag),
    .st_data_o (st_data),
    .st_dom_o  (st_dom)
  );

  // youngest stage doubles as the register-file write port
  assign rf_we_o   = st_vld[0];
  assign rf_tag_o  = st_tag[0];
  assign rf_data_o = st_data[0];

  for (genvar c = 0; c < NUM_LOOKUPS; c++) begin : g_lk
    bypass_lookup #(
      .NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .DEPTH(DEPTH), .XDOM_DLY(XDOM_DLY)
    ) u_lookup (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .st_vld_i  (st_vld),
      .st_tag_i  (st_tag),
      .st_data_i (st_data),
      .st_dom_i  (st_dom),
      .req_i     (lk_req_i[c]),
      .tag_i     (lk_tag_i[c]),
      .dom_i     (lk_dom_i[c]),
      .hit_o     (lk_hit_o[c]),
      .data_o    (lk_data_o[c])
    );
  end

  assert_rf_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (rf_we_o == $past(res_vld_i)));

  assert_rf_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && rf_we_o[0]) |-> (rf_data_o[0] == $past(res_data_i[0])));

endmodule

// File: tb/bypass_net_tb_top.sv
module bypass_net_tb_top;
  localparam int P  = 3;
  localparam int C  = 4;
  localparam int TW = 7;
  localparam int DW = 64;
  localparam int XD = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [P-1:0]          res_vld;
  logic [P-1:0][TW-1:0]  res_tag;
  logic [P-1:0][DW-1:0]  res_data;
  logic [P-1:0][1:0]     res_dom;
  logic [C-1:0]          lk_req;
  logic [C-1:0][TW-1:0]  lk_tag;
  logic [C-1:0][1:0]     lk_dom;
  logic [C-1:0]          lk_hit;
  logic [C-1:0][DW-1:0]  lk_data;
  logic [P-1:0]          rf_we;
  logic [P-1:0][TW-1:0]  rf_tag;
  logic [P-1:0][DW-1:0]  rf_data;

  bypass_net #(.NUM_PORTS(P), .NUM_LOOKUPS(C), .TAG_W(TW), .DATA_W(DW), .XDOM_DLY(XD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .res_vld_i(res_vld), .res_tag_i(res_tag), .res_data_i(res_data), .res_dom_i(res_dom),
    .lk_req_i(lk_req), .lk_tag_i(lk_tag), .lk_dom_i(lk_dom),
    .lk_hit_o(lk_hit), .lk_data_o(lk_data),
    .rf_we_o(rf_we), .rf_tag_o(rf_tag), .rf_data_o(rf_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          age;
    int          port;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
    logic [1:0]    dom;
  } ent_t;

  ent_t q[$];
  ent_t nq[$];
  logic [P-1:0]         e_we;
  logic [P-1:0][TW-1:0] e_tag;
  logic [P-1:0][DW-1:0] e_data;

  // reference: every entry ages by one per clock and is dropped past XD
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      e_we = '0; e_tag = '0; e_data = '0;
    end else begin
      nq.delete();
      foreach (q[i]) begin
        ent_t e;
        e = q[i];
        e.age = e.age + 1;
        if (e.age <= XD) nq.push_back(e);
      end
      for (int p = 0; p < P; p++) begin
        if (res_vld[p]) begin
          ent_t e;
          e.age = 0; e.port = p; e.tag = res_tag[p]; e.data = res_data[p]; e.dom = res_dom[p];
          nq.push_back(e);
        end
      end
      q = nq;
      e_we = res_vld; e_tag = res_tag; e_data = res_data;
    end
  end

  task automatic chk(input string lab, input logic [DW:0] got, input logic [DW:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", lab, got, exp, $time);
    end
  endtask

  function automatic void mlook(input logic [TW-1:0] t, input logic [1:0] d,
                                output logic h, output logic [DW-1:0] v, output string lab);
    int ba = 1000;
    int bp = 1000;
    int nc = 0;
    bit any = 0;
    bit xd = 0;
    h = 1'b0; v = '0;
    foreach (q[i]) begin
      if (q[i].tag == t) begin
        any = 1;
        if (q[i].dom == d || q[i].age >= XD) begin
          nc++;
          if (q[i].age < ba || (q[i].age == ba && q[i].port < bp)) begin
            ba = q[i].age; bp = q[i].port; v = q[i].data; h = 1'b1; xd = (q[i].dom != d);
          end
        end
      end
    end
    if (nc > 1)      lab = "R6 R7";
    else if (h)      lab = xd ? "R4" : "R3";
    else if (any)    lab = "R4";
    else             lab = "R5 R9";
  endfunction

  task automatic compare_all();
    for (int c = 0; c < C; c++) begin
      logic h;
      logic [DW-1:0] v;
      string lab;
      if (lk_req[c]) mlook(lk_tag[c], lk_dom[c], h, v, lab);
      else begin h = 1'b0; v = '0; lab = "R8"; end
      chk(lab, {lk_hit[c], lk_data[c]}, {h, v});
    end
    for (int p = 0; p < P; p++) begin
      chk("R2 R10", {{DW{1'b0}}, rf_we[p]}, {{DW{1'b0}}, e_we[p]});
      if (e_we[p]) begin
        chk("R2", {{(DW+1-TW){1'b0}}, rf_tag[p]}, {{(DW+1-TW){1'b0}}, e_tag[p]});
        chk("R2", {1'b0, rf_data[p]}, {1'b0, e_data[p]});
      end
    end
  endtask

  task automatic idle();
    res_vld = '0; res_tag = '0; res_data = '0; res_dom = '0;
    lk_req = '0; lk_tag = '0; lk_dom = '0;
  endtask

  // apply stimulus at negedge, judge shortly after
  task automatic step();
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic put(input int p, input logic [TW-1:0] t, input logic [DW-1:0] v, input logic [1:0] d);
    res_vld[p] = 1'b1; res_tag[p] = t; res_data[p] = v; res_dom[p] = d;
  endtask

  task automatic ask(input int c, input logic [TW-1:0] t, input logic [1:0] d);
    lk_req[c] = 1'b1; lk_tag[c] = t; lk_dom[c] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    lk_req = '1;
    repeat (3) @(negedge clk);
    #1;
    for (int c = 0; c < C; c++) chk("R1", {lk_hit[c], lk_data[c]}, '0);
    for (int p = 0; p < P; p++) chk("R1", {{DW{1'b0}}, rf_we[p]}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    for (int c = 0; c < C; c++) chk("R1", {lk_hit[c], lk_data[c]}, '0);
    for (int p = 0; p < P; p++) chk("R1", {{DW{1'b0}}, rf_we[p]}, '0);
    idle();

    // R3 R4 R5: one integer result, seen by integer and fp consumers over time
    put(0, 7'd5, 64'hAAAA_0000_0000_0001, 2'd0);
    step(); idle();
    ask(0, 7'd5, 2'd0); ask(1, 7'd5, 2'd1);
    #1;
    chk("R3", {lk_hit[0], lk_data[0]}, {1'b1, 64'hAAAA_0000_0000_0001});
    chk("R4", {lk_hit[1], lk_data[1]}, '0);
    step(); idle();
    ask(0, 7'd5, 2'd0); ask(1, 7'd5, 2'd1); ask(2, 7'd5, 2'd2);
    #1;
    chk("R3", {lk_hit[0], lk_data[0]}, {1'b1, 64'hAAAA_0000_0000_0001});
    chk("R4", {lk_hit[1], lk_data[1]}, {1'b1, 64'hAAAA_0000_0000_0001});
    step(); idle();
    ask(0, 7'd5, 2'd0); ask(1, 7'd5, 2'd1);
    #1;
    chk("R5", {lk_hit[0], lk_data[0]}, '0);
    chk("R5", {lk_hit[1], lk_data[1]}, '0);
    step(); idle();

    // R6: same tag written twice in a row, young wins for its own domain
    put(1, 7'd9, 64'hB, 2'd1);
    step(); idle();
    put(2, 7'd9, 64'hC, 2'd2);
    step(); idle();
    ask(0, 7'd9, 2'd2); ask(1, 7'd9, 2'd1); ask(3, 7'd9, 2'd0);
    #1;
    chk("R6", {lk_hit[0], lk_data[0]}, {1'b1, 64'hC});
    chk("R6", {lk_hit[1], lk_data[1]}, {1'b1, 64'hB});
    chk("R4", {lk_hit[3], lk_data[3]}, {1'b1, 64'hB});
    step(); idle();

    // R7: same cycle, same tag, ports 0 and 2
    put(2, 7'd12, 64'h22, 2'd2);
    put(0, 7'd12, 64'h11, 2'd2);
    step(); idle();
    ask(0, 7'd12, 2'd2);
    #1;
    chk("R7", {lk_hit[0], lk_data[0]}, {1'b1, 64'h11});
    step(); idle();

    // R10: invalid slot carries payload but must stay invisible
    res_tag[1] = 7'd20; res_data[1] = 64'hDEAD; res_dom[1] = 2'd0;
    step(); idle();
    ask(0, 7'd20, 2'd0);
    #1;
    chk("R10", {lk_hit[0], lk_data[0]}, '0);
    chk("R10", {{DW{1'b0}}, rf_we[1]}, '0);
    step(); idle();

    // R8: request low with matching tag present
    put(0, 7'd30, 64'h30, 2'd0);
    step(); idle();
    lk_tag[0] = 7'd30; lk_dom[0] = 2'd0;
    #1;
    chk("R8", {lk_hit[0], lk_data[0]}, '0);
    step(); idle();

    // random phase with a small tag pool
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < P; p++) begin
        res_vld[p]  = ($urandom_range(0, 3) != 0);
        res_tag[p]  = TW'($urandom_range(0, 7));
        res_data[p] = {$urandom(), $urandom()};
        res_dom[p]  = 2'($urandom_range(0, 2));
      end
      for (int c = 0; c < C; c++) begin
        lk_req[c] = ($urandom_range(0, 7) != 0);
        lk_tag[c] = TW'($urandom_range(0, 7));
        lk_dom[c] = 2'($urandom_range(0, 2));
      end
      step();
    end
    idle();
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule